// File: doc/BRIEF.md
# Load/Store Peripheral Router

This block sits on the load/store side of a small processor core, between the core and two targets. One target is the data memory. The other is a set of board I/O registers: slide switches, push buttons, a bank of LEDs and two display value registers. On each access the router inspects the effective address. If bit 31 is set (the address is negative when read as signed), the access goes to the I/O registers. Otherwise it is forwarded to data memory as a word address into a 2^14-word space.

Reads of input peripherals return the switch or button level on the low bits, zero-padded to 32 bits. Writes to output peripherals are captured into registers on the next clock edge and drive the LED and display pins directly. The memory array, switch debouncing and display scanning are outside this block.

Top module: `mmio_bridge`

## Requirements
- R1: When `core_addr[31]` is 1, `mem_en` and `mem_we` are both 0. When it is 0, `mem_en` equals `core_rd | core_wr` and `mem_we` equals `core_wr`. With no access, neither is asserted.
- R2: `mem_addr` equals `core_addr[15:2]` (a word index), and `mem_wdata` equals `core_wdata`.
- R3: A read of 0xFFFFFC00 returns `{16'h0, sw_in[15:0]}` in the same cycle.
- R4: A read of 0xFFFFFC10 returns the left eight switches, `sw_in[15:8]`, on bits 7:0, with all other bits 0.
- R5: A read of 0xFFFFFC20 + 2*k (k = 0..3) returns `btn_in[k]` on bit 0, with all other bits 0.
- R6: A write to 0xFFFFFC40 loads `core_wdata[15:0]` into `led_out` at the next clock edge.
- R7: A write to 0xFFFFFC60 loads `core_wdata[7:0]` into `led_out[7:0]` (the right eight LEDs) and leaves `led_out[15:8]` unchanged.
- R8: A write to 0xFFFFFC69 loads all 32 bits into `disp_wide_out`. A write to 0xFFFFFC70 loads `core_wdata[15:0]` into `disp_narrow_out`.
- R9: A read of any other address with bit 31 set returns 0, including the output register addresses. A write to any such address changes no output register. A read of an output address also changes no output register.
- R10: A synchronous reset sets `led_out` to 16'hFFFF and clears both display registers.
- R11: A read with `core_addr[31]` = 0 returns `mem_rdata` on `core_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_addr | input | 32 | Effective byte address from the core |
| core_wdata | input | 32 | Store data from the core |
| core_rd | input | 1 | Load request |
| core_wr | input | 1 | Store request |
| core_rdata | output | 32 | Load data returned to the core |
| mem_en | output | 1 | Data memory enable |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | 14 | Data memory word index |
| mem_wdata | output | 32 | Data memory write data |
| mem_rdata | input | 32 | Data memory read data |
| sw_in | input | 16 | Slide switch levels |
| btn_in | input | 4 | Push button levels |
| led_out | output | 16 | LED drive register |
| disp_wide_out | output | 32 | 32-bit display value register |
| disp_narrow_out | output | 16 | 16-bit display value register |

## Verification
The assertions assume that `core_rd` and `core_wr` are never high in the same cycle, since the core issues at most one memory operation per instruction. The stimulus raises only one of them at a time and lowers both between accesses. The assertions also assume that the address and write data are stable across the clock edge that captures a store. The bench changes these inputs only at the falling edge, so they hold steady around every rising edge.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int MEM_AW    = 14;
    localparam int SW_W      = 16;
    localparam int BTN_N     = 4;
    localparam int BTN_IDX_W = $clog2(BTN_N);
    localparam int LED_W     = 16;
    localparam int NARROW_W  = 16;
    localparam int LEFT_W    = 8;
    localparam int RIGHT_W   = 8;

    localparam logic [ADDR_W-1:0] ADR_SW_ALL       = 32'hFFFF_FC00;
    localparam logic [ADDR_W-1:0] ADR_SW_LEFT      = 32'hFFFF_FC10;
    localparam logic [ADDR_W-1:0] ADR_BTN_BASE     = 32'hFFFF_FC20;
    localparam int                BTN_STRIDE       = 2;
    localparam logic [ADDR_W-1:0] ADR_LED_ALL      = 32'hFFFF_FC40;
    localparam logic [ADDR_W-1:0] ADR_LED_RIGHT    = 32'hFFFF_FC60;
    localparam logic [ADDR_W-1:0] ADR_DISP_WIDE    = 32'hFFFF_FC69;
    localparam logic [ADDR_W-1:0] ADR_DISP_NARROW  = 32'hFFFF_FC70;

    localparam logic [LED_W-1:0] LED_RESET = '1;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_SW_ALL,
        RD_SW_LEFT,
        RD_BUTTON
    } rd_sel_e;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_LED_ALL,
        WR_LED_RIGHT,
        WR_DISP_WIDE,
        WR_DISP_NARROW
    } wr_sel_e;

    typedef struct packed {
        logic                 is_io;
        logic                 mem_access;
        logic                 mem_write;
        rd_sel_e              rsel;
        wr_sel_e              wsel;
        logic [BTN_IDX_W-1:0] btn_idx;
    } route_t;

    function automatic logic addr_is_io(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic logic [ADDR_W-1:0] btn_addr(input int k);
        return ADR_BTN_BASE + ADDR_W'(k * BTN_STRIDE);
    endfunction

    function automatic wr_sel_e decode_write(input logic [ADDR_W-1:0] a);
        case (a)
            ADR_LED_ALL:     return WR_LED_ALL;
            ADR_LED_RIGHT:   return WR_LED_RIGHT;
            ADR_DISP_WIDE:   return WR_DISP_WIDE;
            ADR_DISP_NARROW: return WR_DISP_NARROW;
            default:         return WR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output route_t            route
);

    logic [BTN_N-1:0]     btn_hit;
    logic [BTN_IDX_W-1:0] btn_idx;

    for (genvar k = 0; k < BTN_N; k++) begin : g_btn_hit
        assign btn_hit[k] = (addr == btn_addr(k));
    end

    always_comb begin
        btn_idx = '0;
        for (int k = 0; k < BTN_N; k++) begin
            if (btn_hit[k]) btn_idx = BTN_IDX_W'(k);
        end
    end

    always_comb begin
        route            = '0;
        route.is_io      = addr_is_io(addr);
        route.mem_access = (rd | wr) & ~route.is_io;
        route.mem_write  = wr & ~route.is_io;
        route.rsel       = RD_NONE;
        route.wsel       = WR_NONE;
        route.btn_idx    = btn_idx;
        if (route.is_io && rd) begin
            if (addr == ADR_SW_ALL)       route.rsel = RD_SW_ALL;
            else if (addr == ADR_SW_LEFT) route.rsel = RD_SW_LEFT;
            else if (|btn_hit)            route.rsel = RD_BUTTON;
        end
        if (route.is_io && wr) begin
            route.wsel = decode_write(addr);
        end
    end

endmodule

// File: rtl/mmio_inputs.sv
module mmio_inputs
    import mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  route_t            route,
    input  logic [SW_W-1:0]   sw_in,
    input  logic [BTN_N-1:0]  btn_in,
    output logic [DATA_W-1:0] io_rdata
);

    always_comb begin
        io_rdata = '0;
        unique case (route.rsel)
            RD_SW_ALL:  io_rdata[SW_W-1:0]   = sw_in;
            RD_SW_LEFT: io_rdata[LEFT_W-1:0] = sw_in[SW_W-1 -: LEFT_W];
            RD_BUTTON:  io_rdata[0]          = btn_in[route.btn_idx];
            default:    io_rdata             = '0;
        endcase
    end

    assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (route.is_io && route.rsel == RD_NONE) |-> (io_rdata == '0));

    assert_button_single_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (route.rsel == RD_BUTTON) |-> (io_rdata[DATA_W-1:1] == '0));

    assert_left_switch_pad_R4: assert property (@(posedge clk) disable iff (rst)
        (route.rsel == RD_SW_LEFT) |-> (io_rdata[DATA_W-1:LEFT_W] == '0));

endmodule

// File: rtl/mmio_outputs.sv
module mmio_outputs
    import mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  route_t            route,
    input  logic [DATA_W-1:0] wdata,
    output logic [LED_W-1:0]  led_q,
    output logic [DATA_W-1:0] disp_wide_q,
    output logic [NARROW_W-1:0] disp_narrow_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q         <= LED_RESET;
            disp_wide_q   <= '0;
            disp_narrow_q <= '0;
        end else begin
            unique case (route.wsel)
                WR_LED_ALL:     led_q                <= wdata[LED_W-1:0];
                WR_LED_RIGHT:   led_q[RIGHT_W-1:0]   <= wdata[RIGHT_W-1:0];
                WR_DISP_WIDE:   disp_wide_q          <= wdata;
                WR_DISP_NARROW: disp_narrow_q        <= wdata[NARROW_W-1:0];
                default: ;
            endcase
        end
    end

    assert_right_led_keeps_left_R7: assert property (@(posedge clk) disable iff (rst)
        (route.wsel == WR_LED_RIGHT) |=> (led_q[LED_W-1:RIGHT_W] == $past(led_q[LED_W-1:RIGHT_W])));

    assert_no_write_no_change_R9: assert property (@(posedge clk) disable iff (rst)
        (route.wsel == WR_NONE) |=> ($stable(led_q) && $stable(disp_wide_q) && $stable(disp_narrow_q)));

    assert_wide_display_load_R8: assert property (@(posedge clk) disable iff (rst)
        (route.wsel == WR_DISP_WIDE) |=> (disp_wide_q == $past(wdata)));

    assert_led_full_load_R6: assert property (@(posedge clk) disable iff (rst)
        (route.wsel == WR_LED_ALL) |=> (led_q == $past(wdata[LED_W-1:0])));

endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
    import mmio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic [DATA_W-1:0]   core_wdata,
    input  logic                core_rd,
    input  logic                core_wr,
    output logic [DATA_W-1:0]   core_rdata,
    output logic                mem_en,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [SW_W-1:0]     sw_in,
    input  logic [BTN_N-1:0]    btn_in,
    output logic [LED_W-1:0]    led_out,
    output logic [DATA_W-1:0]   disp_wide_out,
    output logic [NARROW_W-1:0] disp_narrow_out
);

    localparam int WORD_LSB = $clog2(DATA_W / 8);

    route_t            route;
    logic [DATA_W-1:0] io_rdata;

    mmio_decode u_decode (
        .addr  (core_addr),
        .rd    (core_rd),
        .wr    (core_wr),
        .route (route)
    );

    mmio_inputs u_inputs (
        .clk      (clk),
        .rst      (rst),
        .route    (route),
        .sw_in    (sw_in),
        .btn_in   (btn_in),
        .io_rdata (io_rdata)
    );

    mmio_outputs u_outputs (
        .clk           (clk),
        .rst           (rst),
        .route         (route),
        .wdata         (core_wdata),
        .led_q         (led_out),
        .disp_wide_q   (disp_wide_out),
        .disp_narrow_q (disp_narrow_out)
    );

    assign mem_en     = route.mem_access;
    assign mem_we     = route.mem_write;
    assign mem_addr   = core_addr[WORD_LSB +: MEM_AW];
    assign mem_wdata  = core_wdata;
    assign core_rdata = route.is_io ? io_rdata : mem_rdata;

    assert_io_keeps_memory_idle_R1: assert property (@(posedge clk) disable iff (rst)
        core_addr[ADDR_W-1] |-> (!mem_en && !mem_we));

    assert_store_reaches_memory_R1: assert property (@(posedge clk) disable iff (rst)
        (core_wr && !core_addr[ADDR_W-1]) |-> (mem_en && mem_we));

    assert_single_op_R1: assert property (@(posedge clk) disable iff (rst)
        !(core_rd && core_wr));

endmodule

// File: tb/mmio_bridge_bench.sv
module mmio_bridge_bench;

    typedef struct packed {
        logic        is_wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  btn;
        logic [31:0] exp_rd;
        logic [15:0] exp_led;
        logic [31:0] exp_wide;
        logic [15:0] exp_narrow;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'hFFFF_FC00, 32'h0000_A5C3, 4'h0, 32'h0000_A5C3, 16'hFFFF, 32'h0, 16'h0},
        '{1'b0, 32'hFFFF_FC10, 32'h0000_A5C3, 4'h0, 32'h0000_00A5, 16'hFFFF, 32'h0, 16'h0},
        '{1'b0, 32'hFFFF_FC20, 32'h0,         4'h1, 32'h1,         16'hFFFF, 32'h0, 16'h0},
        '{1'b0, 32'hFFFF_FC22, 32'h0,         4'h2, 32'h1,         16'hFFFF, 32'h0, 16'h0},
        '{1'b0, 32'hFFFF_FC24, 32'h0,         4'h4, 32'h1,         16'hFFFF, 32'h0, 16'h0},
        '{1'b0, 32'hFFFF_FC26, 32'h0,         4'h8, 32'h1,         16'hFFFF, 32'h0, 16'h0},
        '{1'b0, 32'hFFFF_FC22, 32'h0,         4'hD, 32'h0,         16'hFFFF, 32'h0, 16'h0},
        '{1'b0, 32'hFFFF_FC04, 32'h0000_FFFF, 4'hF, 32'h0,         16'hFFFF, 32'h0, 16'h0},
        '{1'b1, 32'hFFFF_FC40, 32'h1234_ABCD, 4'h0, 32'h0,         16'hABCD, 32'h0, 16'h0},
        '{1'b1, 32'hFFFF_FC60, 32'hFFFF_FF5A, 4'h0, 32'h0,         16'hAB5A, 32'h0, 16'h0},
        '{1'b1, 32'hFFFF_FC69, 32'hDEAD_BEEF, 4'h0, 32'h0,         16'hAB5A, 32'hDEAD_BEEF, 16'h0},
        '{1'b1, 32'hFFFF_FC70, 32'h8765_4321, 4'h0, 32'h0,         16'hAB5A, 32'hDEAD_BEEF, 16'h4321},
        '{1'b1, 32'hFFFF_FC44, 32'h0000_0000, 4'h0, 32'h0,         16'hAB5A, 32'hDEAD_BEEF, 16'h4321},
        '{1'b1, 32'hFFFF_FC6C, 32'h1111_1111, 4'h0, 32'h0,         16'hAB5A, 32'hDEAD_BEEF, 16'h4321},
        '{1'b1, 32'h8000_0040, 32'h2222_2222, 4'h0, 32'h0,         16'hAB5A, 32'hDEAD_BEEF, 16'h4321}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] core_addr, core_wdata, core_rdata, mem_wdata, mem_rdata;
    logic        core_rd, core_wr, mem_en, mem_we;
    logic [13:0] mem_addr;
    logic [15:0] sw_in, led_out, disp_narrow_out;
    logic [3:0]  btn_in;
    logic [31:0] disp_wide_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mmio_bridge u_mmio_bridge (
        .clk(clk), .rst(rst), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rd(core_rd), .core_wr(core_wr), .core_rdata(core_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sw_in(sw_in), .btn_in(btn_in), .led_out(led_out),
        .disp_wide_out(disp_wide_out), .disp_narrow_out(disp_narrow_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        core_rd = 1'b0; core_wr = 1'b0;
    endtask

    task automatic chk_outputs(input string req, input logic [15:0] l,
                               input logic [31:0] w, input logic [15:0] n);
        chk({req, " led"}, {16'h0, led_out}, {16'h0, l});
        chk({req, " wide"}, disp_wide_out, w);
        chk({req, " narrow"}, {16'h0, disp_narrow_out}, {16'h0, n});
    endtask

    initial begin
        rst = 1'b1; idle();
        core_addr = '0; core_wdata = '0; mem_rdata = '0; sw_in = '0; btn_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset values
        chk_outputs("R10 reset", 16'hFFFF, 32'h0, 16'h0);
        // R1: idle, no memory enable
        chk("R1 idle mem_en", {31'h0, mem_en}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            core_addr = VECS[i].addr;
            btn_in    = VECS[i].btn;
            if (VECS[i].is_wr) begin
                core_wdata = VECS[i].data; core_wr = 1'b1;
            end else begin
                sw_in = VECS[i].data[15:0]; core_rd = 1'b1;
            end
            #1;
            chk("R1 io mem_en", {30'h0, mem_en, mem_we}, 32'h0);
            if (!VECS[i].is_wr)
                chk("R3 R4 R5 R9 io read", core_rdata, VECS[i].exp_rd);
            @(negedge clk);
            idle();
            #1;
            chk_outputs("R6 R7 R8 R9 io regs", VECS[i].exp_led, VECS[i].exp_wide, VECS[i].exp_narrow);
        end

        // R9: read of an output address returns 0 and changes nothing
        @(negedge clk);
        core_addr = 32'hFFFF_FC40; core_rd = 1'b1; #1;
        chk("R9 read of output addr", core_rdata, 32'h0);
        @(negedge clk); idle(); #1;
        chk_outputs("R9 read leaves regs", 16'hAB5A, 32'hDEAD_BEEF, 16'h4321);

        // R11, R2: memory read path
        @(negedge clk);
        core_addr = 32'h0000_1234; mem_rdata = 32'hCAFE_F00D; core_rd = 1'b1; #1;
        chk("R11 mem read data", core_rdata, 32'hCAFE_F00D);
        chk("R1 mem read enables", {30'h0, mem_en, mem_we}, 32'h2);
        chk("R2 word index", {18'h0, mem_addr}, 32'h48D);

        // R1, R2: memory write path
        @(negedge clk); idle();
        core_addr = 32'h0000_FFFC; core_wdata = 32'h5555_AAAA; core_wr = 1'b1; #1;
        chk("R1 mem write enables", {30'h0, mem_en, mem_we}, 32'h3);
        chk("R2 top word index", {18'h0, mem_addr}, 32'h3FFF);
        chk("R2 write data", mem_wdata, 32'h5555_AAAA);
        @(negedge clk); idle(); #1;
        chk_outputs("R1 mem store leaves io", 16'hAB5A, 32'hDEAD_BEEF, 16'h4321);

        // R1: negative-address store stays off memory
        @(negedge clk);
        core_addr = 32'hFFFF_FC40; core_wdata = 32'h0000_0F0F; core_wr = 1'b1; #1;
        chk("R1 negative store", {30'h0, mem_en, mem_we}, 32'h0);
        @(negedge clk); idle(); #1;
        chk("R6 second led write", {16'h0, led_out}, 32'h0F0F);

        // R10: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk_outputs("R10 reset again", 16'hFFFF, 32'h0, 16'h0);

        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule